// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compares

The block is a symmetric, centre-aligned PWM generator. An up/down counter rises from zero to a programmable ceiling and falls back to zero, one step per timer tick. Two compare channels turn the counter into waveform outputs. The counter takes its ceiling either from a dedicated register or from the active value of compare channel A. Compare values are written into shadow buffers. The active compares pick up these buffers only when the counter leaves zero, so every period has equal rising and falling halves, and a change of period never produces a malformed cycle.

Timer ticks come from a free-running prefilter that divides the system clock by one of five ratios, or stop the counter entirely. Four sticky event flags record zero, ceiling and compare events. Each flag is gated by its own enable to form an interrupt request. Software reaches the block through a write-only register port: address 0 holds the configuration byte, 1 the channel A buffer, 2 the channel B buffer, 3 the ceiling register, 4 the interrupt enables, and 5 clears flags.

Top module: `dualSlopePwm`

## Requirements
- R1: On each tick the count moves by one step through the sequence 0, 1, …, CEIL, CEIL-1, …, 1, 0, 1, …; a count above the ceiling while rising turns downward; a ceiling of 0 holds the count at 0.
- R2: Configuration bit 3 selects the ceiling: 0 uses the ceiling register (address 3), which takes effect on the next tick after the write; 1 uses the active compare A value.
- R3: Writes to addresses 1 and 2 reach only the buffers; the buffers are copied into the active compares on a tick that finds the count at 0, and in that same clock cycle flag bit 0 sets.
- R4: Flag bit 1 sets on a tick at count equal to the ceiling while the ceiling register is selected; flag bits 2 and 3 set on a tick at count equal to active compare A or B; a compare above the ceiling never sets its flag.
- R5: Output mode 2 (configuration bits 5:4 for A, 7:6 for B) drives the channel high while the count is below the compare and low otherwise, so it goes low at the matching step on the way up and high at the matching step on the way down; a compare of 0 gives a constant low, and a compare at or above the ceiling gives a constant high.
- R6: Output mode 3 drives the inverse of the mode 2 level.
- R7: Output mode 1 on channel A, with the ceiling taken from compare A, toggles the output on every compare A match, which gives a 50% square wave; mode 1 in any other case and mode 0 drive the output low.
- R8: Configuration bits 2:0 select the tick: 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks from a divider that runs freely from reset; 0, 6 and 7 give no ticks. Without ticks the count and both outputs hold even across register writes.
- R9: Flags stay set until a write to address 5 with a 1 in their bit position; a set event in the same cycle wins; interrupt request bit i equals flag bit i ANDed with enable bit i (address 4, bits 3:0).
- R10: After reset the count, the outputs, the flags and the interrupt requests are all 0, and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | WIDTH | Register write data |
| count | output | WIDTH | Current counter value |
| pwmA | output | 1 | Channel A waveform |
| pwmB | output | 1 | Channel B waveform |
| flags | output | 4 | Sticky flags: 0 zero, 1 ceiling register, 2 match A, 3 match B |
| irq | output | 4 | Interrupt requests, flags gated by enables |

## Verification
The bench builds the block with its default 16-bit counter and writes small ceilings of 0 to 5 at run time. Full periods, buffered reloads, ceiling switches and compares above the ceiling therefore recur many times within a few hundred clocks. Because the divider is free-running and short periods are used, the /8, /64 and /1024 tick rates can each be covered within a few thousand cycles. A behavioural model in the bench follows the count, both waveforms, the flags and the requests on every clock.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
  localparam int PRESC_W = 10;
  localparam int NUM_FLAGS = 4;

  localparam logic [2:0] ADDR_CFG   = 3'd0;
  localparam logic [2:0] ADDR_BUFA  = 3'd1;
  localparam logic [2:0] ADDR_BUFB  = 3'd2;
  localparam logic [2:0] ADDR_CEIL  = 3'd3;
  localparam logic [2:0] ADDR_IEN   = 3'd4;
  localparam logic [2:0] ADDR_CLEAR = 3'd5;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_LOW_UP = 2'd2,
    OM_HIGH_UP = 2'd3
  } outMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     tick;
    logic     ceilFromA;
    outMode_e modeA;
    outMode_e modeB;
  } ctlStrb_t;

  // datapath -> control events
  typedef struct packed {
    logic matchB;
    logic matchA;
    logic ceilHit;
    logic bottom;
  } dpEvt_t;
endpackage

// File: rtl/pwmCtrl.sv
module pwmCtrl
  import dspwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  dpEvt_t           evt,
  output ctlStrb_t         strb,
  output logic [WIDTH-1:0] bufA,
  output logic [WIDTH-1:0] bufB,
  output logic [WIDTH-1:0] ceilReg,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] irq
);
  logic [2:0]         clkSel;
  logic               ceilFromA;
  outMode_e           modeA, modeB;
  logic [NUM_FLAGS-1:0] irqEn;
  logic [NUM_FLAGS-1:0] flagR;
  logic [NUM_FLAGS-1:0] flagSet, flagClr;
  logic [PRESC_W-1:0] presc;
  logic               tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end

  always_comb begin
    unique case (clkSel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &presc[2:0];
      3'd3:    tick = &presc[5:0];
      3'd4:    tick = &presc[7:0];
      3'd5:    tick = &presc[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign flagSet = {evt.matchB, evt.matchA, evt.ceilHit, evt.bottom};
  assign flagClr = (wrEn && wrAddr == ADDR_CLEAR) ? wrData[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel    <= 3'd0;
      ceilFromA <= 1'b0;
      modeA     <= OM_OFF;
      modeB     <= OM_OFF;
      bufA      <= '0;
      bufB      <= '0;
      ceilReg   <= '1;
      irqEn     <= '0;
      flagR     <= '0;
    end else begin
      flagR <= (flagR & ~flagClr) | flagSet;
      if (wrEn) begin
        unique case (wrAddr)
          ADDR_CFG: begin
            clkSel    <= wrData[2:0];
            ceilFromA <= wrData[3];
            modeA     <= outMode_e'(wrData[5:4]);
            modeB     <= outMode_e'(wrData[7:6]);
          end
          ADDR_BUFA: bufA    <= wrData;
          ADDR_BUFB: bufB    <= wrData;
          ADDR_CEIL: ceilReg <= wrData;
          ADDR_IEN:  irqEn   <= wrData[NUM_FLAGS-1:0];
          default: ;
        endcase
      end
    end
  end

  assign strb.tick      = tick;
  assign strb.ceilFromA = ceilFromA;
  assign strb.modeA     = modeA;
  assign strb.modeB     = modeB;
  assign flags = flagR;
  assign irq   = flagR & irqEn;
endmodule

// File: rtl/pwmDatapath.sv
module pwmDatapath
  import dspwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [WIDTH-1:0] bufA,
  input  logic [WIDTH-1:0] bufB,
  input  logic [WIDTH-1:0] ceilReg,
  output dpEvt_t           evt,
  output logic [WIDTH-1:0] count,
  output logic             pwmA,
  output logic             pwmB
);
  logic [WIDTH-1:0] cnt, cntNext, cmpA, cmpB, cmpANext, cmpBNext, ceil, ceilNext;
  logic down, downNext, atBottom, lvlA, lvlB, outA, outB, outANext, outBNext;

  function automatic logic chanOut(input outMode_e mode, input logic lvl,
                                   input logic togOk, input logic hit, input logic cur);
    unique case (mode)
      OM_OFF:    return 1'b0;
      OM_TOGGLE: return togOk ? (cur ^ hit) : 1'b0;
      OM_LOW_UP: return lvl;
      default:   return ~lvl;
    endcase
  endfunction

  always_comb begin
    ceil     = strb.ceilFromA ? cmpA : ceilReg;
    atBottom = (cnt == '0);
    cmpANext = atBottom ? bufA : cmpA;
    cmpBNext = atBottom ? bufB : cmpB;
    ceilNext = strb.ceilFromA ? cmpANext : ceilReg;

    if (ceil == '0) begin
      cntNext  = '0;
      downNext = 1'b0;
    end else if (!down) begin
      if (cnt >= ceil) begin
        cntNext  = cnt - 1'b1;
        downNext = 1'b1;
      end else begin
        cntNext  = cnt + 1'b1;
        downNext = 1'b0;
      end
    end else if (atBottom) begin
      cntNext  = {{(WIDTH-1){1'b0}}, 1'b1};
      downNext = 1'b0;
    end else begin
      cntNext  = cnt - 1'b1;
      downNext = 1'b1;
    end

    evt.bottom  = strb.tick && atBottom;
    evt.ceilHit = strb.tick && !strb.ceilFromA && (cnt == ceil);
    evt.matchA  = strb.tick && (cnt == cmpA);
    evt.matchB  = strb.tick && (cnt == cmpB);

    lvlA = (cmpANext >= ceilNext) || (cntNext < cmpANext);
    lvlB = (cmpBNext >= ceilNext) || (cntNext < cmpBNext);
    outANext = chanOut(strb.modeA, lvlA, strb.ceilFromA, evt.matchA, outA);
    outBNext = chanOut(strb.modeB, lvlB, 1'b0, evt.matchB, outB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      down <= 1'b0;
      cmpA <= '0;
      cmpB <= '0;
      outA <= 1'b0;
      outB <= 1'b0;
    end else if (strb.tick) begin
      cnt  <= cntNext;
      down <= downNext;
      cmpA <= cmpANext;
      cmpB <= cmpBNext;
      outA <= outANext;
      outB <= outBNext;
    end
  end

  assign count = cnt;
  assign pwmA  = outA;
  assign pwmB  = outB;
endmodule

// File: rtl/dualSlopePwm.sv
module dualSlopePwm
  import dspwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic             pwmA,
  output logic             pwmB,
  output logic [3:0]       flags,
  output logic [3:0]       irq
);
  ctlStrb_t         strb;
  dpEvt_t           evt;
  logic [WIDTH-1:0] bufA, bufB, ceilReg;

  pwmCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evt(evt), .strb(strb), .bufA(bufA), .bufB(bufB), .ceilReg(ceilReg),
    .flags(flags), .irq(irq)
  );

  pwmDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bufA(bufA), .bufB(bufB),
    .ceilReg(ceilReg), .evt(evt), .count(count), .pwmA(pwmA), .pwmB(pwmB)
  );
endmodule

// File: rtl/dualSlopePwmChecker.sv
module dualSlopePwmChecker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [WIDTH-1:0] count,
  input logic             pwmA,
  input logic             pwmB,
  input logic [3:0]       flags,
  input logic [3:0]       irq
);
  // R8: no tick, no counter movement
  p_hold_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  // R8: no tick, outputs frozen
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable({pwmA, pwmB}));

  // R1: each tick moves the count by a single step
  p_single_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)
             || (count == '0));

  // R3: zero flag rises only after a tick at count zero
  p_bottom_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(tick) && ($past(count) == '0));

  // R4: event flags rise only on a tick
  p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) || $rose(flags[2]) || $rose(flags[3]) |-> $past(tick));

  // R9: no request without its flag
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~flags) == 4'b0);
endmodule

bind dualSlopePwm dualSlopePwmChecker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .tick(strb.tick), .count(count),
  .pwmA(pwmA), .pwmB(pwmB), .flags(flags), .irq(irq)
);

// File: tb/tb_dualSlopePwm.sv
module tb_dualSlopePwm;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic pwmA, pwmB;
  logic [3:0] flags, irq;

  int checks = 0;
  int errors = 0;

  dualSlopePwm #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .pwmA(pwmA), .pwmB(pwmB), .flags(flags), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int mPresc, mDiv;
  logic [2:0] mSel;
  logic mTfa, mDown, mTk, mPwmA, mPwmB, lvA, lvB;
  logic [1:0] mModeA, mModeB;
  logic [W-1:0] mBufA, mBufB, mCeilReg, mCmpA, mCmpB, mCnt, nCnt, mTop, nTop;
  logic [3:0] mEn, mFlags, mSet, mClr;
  logic nDown;

  function automatic logic modelOut(input logic [1:0] md, input logic lv,
                                    input logic tog, input logic hit, input logic cur);
    if (md == 2'd0) return 1'b0;
    if (md == 2'd1) return tog ? (cur ^ hit) : 1'b0;
    if (md == 2'd2) return lv;
    return ~lv;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPresc = 0; mSel = 0; mTfa = 0; mModeA = 0; mModeB = 0;
      mBufA = 0; mBufB = 0; mCeilReg = '1; mEn = 0; mFlags = 0;
      mCnt = 0; mDown = 0; mCmpA = 0; mCmpB = 0; mPwmA = 0; mPwmB = 0;
    end else begin
      case (mSel)
        3'd1: mDiv = 1;
        3'd2: mDiv = 8;
        3'd3: mDiv = 64;
        3'd4: mDiv = 256;
        3'd5: mDiv = 1024;
        default: mDiv = 0;
      endcase
      mTk = (mDiv != 0) && ((mPresc % mDiv) == mDiv - 1);
      mPresc = (mPresc + 1) % 1024;
      mSet = 0;
      if (mTk) begin
        mTop = mTfa ? mCmpA : mCeilReg;
        mSet[0] = (mCnt == 0);
        mSet[1] = !mTfa && (mCnt == mTop);
        mSet[2] = (mCnt == mCmpA);
        mSet[3] = (mCnt == mCmpB);
        if (mTop == 0) begin nCnt = 0; nDown = 0; end
        else if (!mDown && mCnt >= mTop) begin nCnt = mCnt - 1; nDown = 1; end
        else if (!mDown) begin nCnt = mCnt + 1; nDown = 0; end
        else if (mCnt == 0) begin nCnt = 1; nDown = 0; end
        else begin nCnt = mCnt - 1; nDown = 1; end
        if (mCnt == 0) begin mCmpA = mBufA; mCmpB = mBufB; end
        nTop = mTfa ? mCmpA : mCeilReg;
        lvA = (mCmpA >= nTop) || (nCnt < mCmpA);
        lvB = (mCmpB >= nTop) || (nCnt < mCmpB);
        mPwmA = modelOut(mModeA, lvA, mTfa, mSet[2], mPwmA);
        mPwmB = modelOut(mModeB, lvB, 1'b0, mSet[3], mPwmB);
        mCnt = nCnt; mDown = nDown;
      end
      mClr = (wrEn && wrAddr == 3'd5) ? wrData[3:0] : 4'd0;
      mFlags = (mFlags & ~mClr) | mSet;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mSel = wrData[2:0]; mTfa = wrData[3];
                      mModeA = wrData[5:4]; mModeB = wrData[7:6]; end
          3'd1: mBufA = wrData;
          3'd2: mBufB = wrData;
          3'd3: mCeilReg = wrData;
          3'd4: mEn = wrData[3:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 count vs model", int'(count), int'(mCnt));
      chk("R5 pwmA vs model", int'(pwmA), int'(mPwmA));
      chk("R6 pwmB vs model", int'(pwmB), int'(mPwmB));
      chk("R4 flags vs model", int'(flags), int'(mFlags));
      chk("R9 irq vs model", int'(irq), int'(mFlags & mEn));
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones, changes, maxCnt;
    logic prevA;
    logic [W-1:0] prevCnt;
    logic [W-1:0] keepCnt;
    logic keepA, keepB;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 count", int'(count), 0);
    chk("R10 pwm", int'({pwmA, pwmB}), 0);
    chk("R10 flags", int'(flags), 0);
    chk("R10 irq", int'(irq), 0);

    // basic dual slope, ceiling register 5, non-inverted A, inverted B
    wr(3'd3, 5); wr(3'd1, 2); wr(3'd2, 3); wr(3'd4, 15);
    wr(3'd0, 'hE1);
    idle(40);

    // R5 extremes: compare 0 -> low, compare = ceiling -> high
    wr(3'd1, 0); wr(3'd2, 5); wr(3'd0, 'hA1);
    idle(20);
    ones = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); ones += int'(pwmA); end
    chk("R5 compare zero stays low", ones, 0);
    ones = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); ones += int'(pwmB); end
    chk("R5 compare at ceiling stays high", ones, 30);

    // R4 compare above ceiling never matches
    wr(3'd2, 9);
    idle(20);
    wr(3'd5, 15);
    idle(30);
    chk("R4 no match above ceiling", int'(flags[3]), 0);

    // R2 ceiling register applies immediately
    wr(3'd3, 3);
    idle(12);
    maxCnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(count) > maxCnt) maxCnt = int'(count);
    end
    chk("R2 new ceiling bounds count", maxCnt, 3);

    // R7 ceiling from compare A, toggle mode on A
    wr(3'd1, 4); wr(3'd0, 'h99);
    idle(20);
    changes = 0; prevA = pwmA;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pwmA != prevA) changes++;
      prevA = pwmA;
    end
    chk("R7 toggle once per period", changes, 8);

    // R8 divide by 8
    wr(3'd0, 'h9A);
    idle(16);
    changes = 0; prevCnt = count;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (count != prevCnt) changes++;
      prevCnt = count;
    end
    chk("R8 divide by 8 tick rate", changes, 8);

    // R8 slower ratios, model compared each clock
    wr(3'd0, 'h9B); idle(300);
    wr(3'd0, 'h9C); idle(600);
    wr(3'd0, 'h9D); idle(2200);

    // R8 stop: count and outputs frozen across writes
    wr(3'd0, 'h98);
    keepCnt = count; keepA = pwmA; keepB = pwmB;
    wr(3'd2, 1); wr(3'd3, 2); wr(3'd1, 1);
    idle(20);
    chk("R8 stopped count holds", int'(count), int'(keepCnt));
    chk("R8 stopped outputs hold", int'({pwmA, pwmB}), int'({keepA, keepB}));

    // R9 write-one clear and enable gating
    wr(3'd5, 15);
    chk("R9 flags cleared", int'(flags), 0);
    chk("R9 irq cleared", int'(irq), 0);
    wr(3'd4, 1);
    wr(3'd1, 4); wr(3'd0, 'h99);
    idle(30);
    chk("R9 only enabled request", int'(irq), int'(flags & 4'h1));
    chk("R3 zero flag after periods", int'(flags[0]), 1);

    // R1 ceiling 0 holds count; R7 mode 0 and mode 1 on B drive low
    wr(3'd0, 'h41); wr(3'd3, 0);
    idle(4);
    ones = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); ones += int'(count != 0); end
    chk("R1 zero ceiling holds count", ones, 0);
    chk("R7 modes 0 and 1 drive low", int'({pwmA, pwmB}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule